// File: doc/BRIEF.md
# Pipelined Two-Group Carry-Select Adder

This block adds or subtracts two N-bit unsigned operands in a bit-pipelined fashion and accepts a new operand pair on every clock. The operand word is cut into a low group and a high group, each N/2 bits wide. The low group is a skewed ripple chain: one stage per bit, and each stage registers one sum bit and the carry that the next stage consumes. The high group is built twice. Both copies run in step with the low group, one with a carry-in of 0 and one with a carry-in of 1.

When the low chain's carry-out reaches the end of the chain, a single-level multiplexer selects one of the two high-group candidates, with its carry-out. The low sum bits are registered in the same select stage, so both halves of a result appear together. A valid flag travels with the data. In subtract mode operand B is inverted and the low carry-in is forced to 1.

The pipeline has no states. It is a fixed chain of H = N/2 ripple stages followed by one select stage. Every operation goes through the same sequence: enter stage 0, ripple through the stages one per cycle, then be selected and aligned.

Top module: `pcsel_adder`

## Requirements
- R1: A result and its out_valid appear H+1 clock cycles after the operand pair is sampled with in_valid high, where H = N/2.
- R2: With in_sub = 0, {out_cout, out_sum} equals in_a + in_b + in_cin computed to N+1 bits.
- R3: With in_sub = 1, out_sum equals (in_a - in_b) mod 2^N, and out_cout is 1 exactly when in_a >= in_b as unsigned values. in_cin has no effect in this mode.
- R4: A new operation can be issued on every cycle. Consecutive operations, including ones that alternate between add and subtract, give independent results.
- R5: While rst is high and on the cycle after it, out_valid, out_sum and out_cout are 0.
- R6: A carry out of the low group reaches the high group correctly. This includes the case where the low operand bits are all ones and the carry into the low group is 1.
- R7: All ones plus one gives out_sum = 0 with out_cout = 1. Zero plus zero gives out_sum = 0 with out_cout = 0.
- R8: A cycle with in_valid low produces a cycle with out_valid low H+1 cycles later. The gaps in out_valid follow the gaps in in_valid.
- R9: At the output of the high chains, the candidate computed with an assumed carry of 1 equals the candidate computed with an assumed carry of 0, plus one. Both candidates are H+1 bits wide, counting the carry.
- R10: The low sum bits of a result reach the output in the same cycle as the high bits selected for that same operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on this cycle is meaningful |
| in_sub | input | 1 | 1 selects subtract (A - B), 0 selects add |
| in_cin | input | 1 | Carry-in for add mode, ignored in subtract mode |
| in_a | input | N | Operand A |
| in_b | input | N | Operand B |
| out_valid | output | 1 | Result on this cycle is meaningful |
| out_sum | output | N | Sum or difference |
| out_cout | output | 1 | Carry-out, or not-borrow when subtracting |

## Verification
A stale or corrupted carry register inside one of the chains shows up as a wrong bit in exactly one result, H+1 cycles after that operand pair went in. Later operations are not affected, because the pipeline holds no state from one operation to the next. A fault in the high candidate that carries an assumed 1 shows only when the low group really produces a carry, as an off-by-one in the top half. That is why the low-group all-ones boundary is driven directly, and why the two candidates are compared against each other. A misaligned low-half buffer puts the low bits of a neighbouring operation on the output. With back-to-back distinct operands, this shows at once as a mismatch in the low half only.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

    // One-bit full adder, returns {carry, sum}
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic c);
        full_add = {(x & y) | (x & c) | (y & c), x ^ y ^ c};
    endfunction

endpackage

// File: rtl/pcsel_chain.sv
// Skewed ripple chain: stage s consumes operand bit s and the registered
// carry of stage s-1; remaining operand bits shift down one place per stage.
module pcsel_chain
    import pcsel_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    genvar s;
    generate
        for (s = 0; s < W; s++) begin : g_bit
            logic [W-1:0] a_prev, b_prev, sum_prev;
            logic         c_prev;
            logic [W-1:0] opa_r, opb_r, sum_r;
            logic         cy_r;
            logic [1:0]   fa_o;

            if (s == 0) begin : g_head
                assign a_prev   = a;
                assign b_prev   = b;
                assign sum_prev = '0;
                assign c_prev   = cin;
            end else begin : g_body
                assign a_prev   = g_bit[s-1].opa_r;
                assign b_prev   = g_bit[s-1].opb_r;
                assign sum_prev = g_bit[s-1].sum_r;
                assign c_prev   = g_bit[s-1].cy_r;
            end

            assign fa_o = full_add(a_prev[0], b_prev[0], c_prev);

            always_ff @(posedge clk) begin
                if (rst) begin
                    opa_r <= '0;
                    opb_r <= '0;
                    sum_r <= '0;
                    cy_r  <= 1'b0;
                end else begin
                    opa_r <= a_prev >> 1;
                    opb_r <= b_prev >> 1;
                    sum_r <= sum_prev | (W'(fa_o[0]) << s);
                    cy_r  <= fa_o[1];
                end
            end
        end
    endgenerate

    assign sum  = g_bit[W-1].sum_r;
    assign cout = g_bit[W-1].cy_r;

endmodule

// File: rtl/pcsel_delay.sv
// Flag delay line matching the chain depth
module pcsel_delay #(
    parameter int D = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [D-1:0] tap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
        end else begin
            tap_q[0] <= d;
            for (int i = 1; i < D; i++) begin
                tap_q[i] <= tap_q[i-1];
            end
        end
    end

    assign q = tap_q[D-1];

endmodule

// File: rtl/pcsel_select.sv
// One-level selection of the high candidate plus alignment register for the low bits
module pcsel_select #(
    parameter int H = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid_i,
    input  logic [H-1:0]   lo_sum,
    input  logic           lo_cout,
    input  logic [H-1:0]   hi0_sum,
    input  logic           hi0_cout,
    input  logic [H-1:0]   hi1_sum,
    input  logic           hi1_cout,
    output logic           valid_o,
    output logic [2*H-1:0] sum_o,
    output logic           cout_o
);

    logic [H:0] hi_pick;

    always_comb begin
        hi_pick = lo_cout ? {hi1_cout, hi1_sum} : {hi0_cout, hi0_sum};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            sum_o   <= '0;
            cout_o  <= 1'b0;
        end else begin
            valid_o <= valid_i;
            sum_o   <= {hi_pick[H-1:0], lo_sum};
            cout_o  <= hi_pick[H];
        end
    end

endmodule

// File: rtl/pcsel_adder.sv
module pcsel_adder #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_sub,
    input  logic         in_cin,
    input  logic [N-1:0] in_a,
    input  logic [N-1:0] in_b,
    output logic         out_valid,
    output logic [N-1:0] out_sum,
    output logic         out_cout
);

    localparam int H = N / 2;

    logic [N-1:0] b_eff;
    logic         cin_eff;
    logic [H-1:0] lo_sum, hi0_sum, hi1_sum;
    logic         lo_cout, hi0_cout, hi1_cout;
    logic         chain_valid;

    // Subtract: invert B and force carry into low group
    always_comb begin
        b_eff   = in_sub ? ~in_b : in_b;
        cin_eff = in_sub | in_cin;
    end

    pcsel_chain #(.W(H)) u_lo (
        .clk  (clk),
        .rst  (rst),
        .a    (in_a[H-1:0]),
        .b    (b_eff[H-1:0]),
        .cin  (cin_eff),
        .sum  (lo_sum),
        .cout (lo_cout)
    );

    pcsel_chain #(.W(H)) u_hi0 (
        .clk  (clk),
        .rst  (rst),
        .a    (in_a[N-1:H]),
        .b    (b_eff[N-1:H]),
        .cin  (1'b0),
        .sum  (hi0_sum),
        .cout (hi0_cout)
    );

    pcsel_chain #(.W(H)) u_hi1 (
        .clk  (clk),
        .rst  (rst),
        .a    (in_a[N-1:H]),
        .b    (b_eff[N-1:H]),
        .cin  (1'b1),
        .sum  (hi1_sum),
        .cout (hi1_cout)
    );

    pcsel_delay #(.D(H)) u_vld (
        .clk (clk),
        .rst (rst),
        .d   (in_valid),
        .q   (chain_valid)
    );

    pcsel_select #(.H(H)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (chain_valid),
        .lo_sum   (lo_sum),
        .lo_cout  (lo_cout),
        .hi0_sum  (hi0_sum),
        .hi0_cout (hi0_cout),
        .hi1_sum  (hi1_sum),
        .hi1_cout (hi1_cout),
        .valid_o  (out_valid),
        .sum_o    (out_sum),
        .cout_o   (out_cout)
    );

endmodule

// File: rtl/pcsel_adder_chk.sv
module pcsel_adder_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           chain_valid,
    input logic [N/2-1:0] lo_sum,
    input logic [N/2-1:0] hi0_sum,
    input logic           hi0_cout,
    input logic [N/2-1:0] hi1_sum,
    input logic           hi1_cout,
    input logic           out_valid,
    input logic [N-1:0]   out_sum,
    input logic           out_cout
);

    localparam int H = N / 2;

    logic [H:0] cand0, cand1, cand0_inc;

    always_comb begin
        cand0     = {hi0_cout, hi0_sum};
        cand1     = {hi1_cout, hi1_sum};
        cand0_inc = cand0 + 1'b1;
    end

    // R5
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sum == '0 && !out_cout));

    // R9
    cand_step_chk: assert property (@(posedge clk) disable iff (rst)
        chain_valid |-> (cand1 == cand0_inc));

    // R6
    upper_pick_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (({out_cout, out_sum[N-1:H]} == $past(cand0)) ||
                       ({out_cout, out_sum[N-1:H]} == $past(cand1))));

    // R10
    lower_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sum[H-1:0] == $past(lo_sum)));

endmodule

bind pcsel_adder pcsel_adder_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chain_valid (chain_valid),
    .lo_sum      (lo_sum),
    .hi0_sum     (hi0_sum),
    .hi0_cout    (hi0_cout),
    .hi1_sum     (hi1_sum),
    .hi1_cout    (hi1_cout),
    .out_valid   (out_valid),
    .out_sum     (out_sum),
    .out_cout    (out_cout)
);

// File: tb/sim_pcsel_adder.sv
module sim_pcsel_adder;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int H   = W / 2;
    localparam int LAT = H + 1;
    localparam int HD  = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_sub, in_cin;
    logic [W-1:0] in_a, in_b;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_cout;

    int checks = 0;
    int errors = 0;
    int n = 0;

    logic         hv [HD];
    logic [W:0]   hr [HD];
    string        ht [HD];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcsel_adder #(.N(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sub    (in_sub),
        .in_cin    (in_cin),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_cout  (out_cout)
    );

    // Reference result from R2 / R3
    function automatic logic [W:0] ref_calc(input logic sub, input logic cin,
                                            input logic [W-1:0] a, input logic [W-1:0] b);
        if (sub) ref_calc = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        else     ref_calc = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
    endfunction

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Called at a falling edge: check the slot issued LAT cycles ago, then drive
    task automatic step(input logic v, input logic sub, input logic cin,
                        input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        if (n >= LAT) begin
            int k = (n - LAT) % HD;
            check({ht[k], " R1 R8 valid"}, (W+1)'(out_valid), (W+1)'(hv[k]));
            if (hv[k]) check({ht[k], " R10 result"}, {out_cout, out_sum}, hr[k]);
        end else begin
            check("R5 valid low while pipeline fills", (W+1)'(out_valid), '0);
        end
        in_valid = v; in_sub = sub; in_cin = cin; in_a = a; in_b = b;
        hv[n % HD] = v;
        hr[n % HD] = ref_calc(sub, cin, a, b);
        ht[n % HD] = tag;
        n++;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] ones;
        ones = '1;
        void'($urandom(32'd4711));
        rst = 1'b1; in_valid = 1'b0; in_sub = 1'b0; in_cin = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        // R5 reset state
        check("R5 reset outputs", {out_cout, out_sum}, '0);
        check("R5 reset valid", (W+1)'(out_valid), '0);
        rst = 1'b0;

        // Directed corners
        step(1, 0, 0, '0, '0, "R7 zero plus zero");
        step(1, 0, 0, ones, W'(1), "R7 all ones plus one");
        step(1, 0, 1, ones, '0, "R7 all ones plus cin");
        step(1, 0, 1, W'((1 << H) - 1), '0, "R6 R9 low group all ones with cin");
        step(1, 0, 0, W'((1 << H) - 1), W'(1), "R6 R9 low carry into high");
        step(1, 0, 0, W'(8'h3C), W'(8'h5A), "R2 plain add");
        step(1, 1, 0, W'(8'h55), W'(8'h55), "R3 subtract equal");
        step(1, 1, 0, W'(8'h10), W'(8'h20), "R3 subtract borrow");
        step(1, 1, 1, W'(8'h10), W'(8'h20), "R3 subtract cin ignored");
        step(1, 1, 0, '0, ones, "R3 zero minus all ones");
        step(0, 0, 0, ones, ones, "R8 idle gap");
        step(1, 0, 1, ones, ones, "R2 max add");
        step(0, 1, 0, '0, '0, "R8 idle gap");
        step(0, 0, 0, '0, '0, "R8 idle gap");
        // R4 alternating modes back to back
        for (int i = 0; i < 16; i++) begin
            step(1, i[0], i[1], W'(8'hA5 + i * 7), W'(8'h3B + i * 13), "R4 alternating modes");
        end
        // Constrained random with occasional all-ones operands and gaps
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            logic rv;
            ra = W'($urandom());
            rb = W'($urandom());
            if ($urandom_range(0, 7) == 0) ra = ones;
            if ($urandom_range(0, 7) == 0) rb = ones;
            rv = ($urandom_range(0, 3) != 0);
            step(rv, 1'($urandom()), 1'($urandom()), ra, rb, "R2 R3 R4 random");
        end
        // Drain
        for (int i = 0; i < LAT + 2; i++) begin
            step(0, 0, 0, '0, '0, "R8 drain");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule